// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit gathers single-cycle event pulses from a bus transfer engine into sticky status flags. Software sees them through a small register port. It reads the flags from a status register and clears them by writing ones, and it selects which events raise the combined interrupt line through an enable register. The same pending events can also be drained one at a time through a vector register. Each read of that register returns the code of the most urgent pending event and retires that event in the same access. The status word also carries a bus-busy flag, which follows a live level from the bus monitor rather than being latched.

Register addresses on `reg_addr`: 0 selects status, 1 selects enable and 2 selects the vector. Reads return data one cycle after the request. The access sequencer has two states:
- `ACC_IDLE` waits for a read and moves to `ACC_RESP` when one arrives.
- `ACC_RESP` drives `reg_rvalid` high with the captured word. It stays in `ACC_RESP` while back-to-back reads arrive and returns to `ACC_IDLE` otherwise.

A write in the same cycle as a read takes precedence, and that read is dropped.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset, the status, enable and vector registers all read 0, `irq` is 0, and `reg_rvalid` and `reg_rdata` are 0.
- R2: A pulse on `ev_pulse[i]` sets status bit i, and the bit stays set after the pulse ends. This applies to the latched positions only: 0 lost arbitration, 1 missing acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 zero address seen, 9 addressed as target, 10 transmit underrun, 11 receive overrun, 13 receive drain, 14 transmit drain.
- R3: A write to the status register (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged. Several bits may be cleared in one write.
- R4: If a pulse for a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R5: Status bit 12 always shows the current `bus_busy` level. Writing 1 to bit 12 has no effect on it.
- R6: Only enable bits 0 to 4, 13 and 14 can be written. All other enable bits always read 0.
- R7: `irq` is 1 exactly when some status bit and the matching enable bit are both 1. It follows the registers with no extra delay.
- R8: The vector register (address 2) returns 0 when none of status bits 0 to 4 is set. Otherwise it returns the index of the lowest set bit plus 1, giving codes 1 to 5.
- R9: A read of the vector register clears the status bit it reports, so successive reads step through the pending events from the lowest code upward.
- R10: A read request in a cycle without a write gives `reg_rvalid` = 1 with the data in the next cycle.
- R11: Status bits 5, 6, 7 and 15 always read 0, whatever pulses arrive on those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 16 | One-cycle event pulses, placed at their status bit positions |
| bus_busy | input | 1 | Live bus-busy level from the bus monitor |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 vector |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while reg_rvalid is 1 |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read request |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the collision between a new event and the clear of that same bit. The pulse and the write strobe must land on the same clock edge, so the bench drives both on one falling edge. It then reads status to confirm that the colliding bit survived while a second bit in the same write was cleared. Stepping the vector through several pending events is the other case that needs care. The bench first loads three sources with a single pulse word and then issues consecutive vector reads, each of which must retire exactly one event.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int NUM_VEC  = 5;
    localparam int CODE_W   = 3;
    localparam int BUSY_BIT = 12;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_VEC  = 2'd2;

    // latched event positions and enable-capable positions
    localparam logic [DATA_W-1:0] STICKY_MASK = 16'h6F1F;
    localparam logic [DATA_W-1:0] EN_MASK     = 16'h601F;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int                W           = irq_pkg::DATA_W,
    parameter logic [W-1:0]      STICKY_MASK = irq_pkg::STICKY_MASK,
    parameter int                BUSY_BIT    = irq_pkg::BUSY_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse,
    input  logic [W-1:0] clr,
    input  logic         busy,
    output logic [W-1:0] status
);
    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q[i] <= 1'b0;
                else
                    flag_q[i] <= (flag_q[i] & ~clr[i]) | pulse[i];
            end
        end else begin : g_none
            assign flag_q[i] = 1'b0;
        end
    end

    always_comb begin
        status           = flag_q;
        status[BUSY_BIT] = busy;
    end

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pulse & STICKY_MASK)) |=>
        ((flag_q & $past(pulse & STICKY_MASK)) == $past(pulse & STICKY_MASK)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~pulse & STICKY_MASK)) |=>
        ((flag_q & $past(clr & ~pulse & STICKY_MASK)) == '0));

    assert_collision_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & pulse & STICKY_MASK)) |=>
        ((flag_q & $past(clr & pulse & STICKY_MASK)) == $past(clr & pulse & STICKY_MASK)));
endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
    parameter int N      = irq_pkg::NUM_VEC,
    parameter int CODE_W = irq_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pend,
    output logic [CODE_W-1:0] code,
    output logic [N-1:0]      sel
);
    always_comb begin
        code = '0;
        sel  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code = CODE_W'(i + 1);
                sel  = '0;
                sel[i] = 1'b1;
            end
        end
    end

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code <= CODE_W'(N)) && ((code == '0) == (pend == '0)));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int N      = NUM_VEC,
    parameter int CW     = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    input  logic [W-1:0]  status,
    input  logic [W-1:0]  enable,
    input  logic [CW-1:0] vec_code,
    input  logic [N-1:0]  vec_sel,
    output logic [W-1:0]  clr,
    output logic          en_we,
    output logic [W-1:0]  rdata,
    output logic          rvalid
);
    acc_state_e state_q, state_d;
    logic       rd_go;
    logic [W-1:0] rdata_q;

    assign rd_go = reg_rd && !reg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_go)  state_d = ACC_RESP;
            ACC_RESP: if (!rd_go) state_d = ACC_IDLE;
            default:              state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_go) begin
            unique case (reg_addr)
                ADDR_STAT: rdata_q <= status;
                ADDR_EN:   rdata_q <= enable;
                ADDR_VEC:  rdata_q <= W'(vec_code);
                default:   rdata_q <= '0;
            endcase
        end
    end

    always_comb begin
        rvalid = (state_q == ACC_RESP);
        rdata  = rvalid ? rdata_q : '0;
        en_we  = reg_wr && (reg_addr == ADDR_EN);
        clr    = '0;
        if (reg_wr && reg_addr == ADDR_STAT)
            clr = reg_wdata;
        else if (rd_go && reg_addr == ADDR_VEC)
            clr = W'(vec_sel);
    end

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rvalid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rvalid);
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev_pulse,
    input  logic              bus_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    logic [DATA_W-1:0]  status;
    logic [DATA_W-1:0]  enable_q;
    logic [DATA_W-1:0]  clr;
    logic               en_we;
    logic [CODE_W-1:0]  vec_code;
    logic [NUM_VEC-1:0] vec_sel;

    irq_status_bank #(
        .W(DATA_W), .STICKY_MASK(STICKY_MASK), .BUSY_BIT(BUSY_BIT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .pulse(ev_pulse), .clr(clr),
        .busy(bus_busy), .status(status)
    );

    irq_vector_enc #(.N(NUM_VEC), .CODE_W(CODE_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .pend(status[NUM_VEC-1:0]),
        .code(vec_code), .sel(vec_sel)
    );

    irq_reg_port #(.W(DATA_W), .AW(ADDR_W), .N(NUM_VEC), .CW(CODE_W)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status),
        .enable(enable_q), .vec_code(vec_code), .vec_sel(vec_sel),
        .clr(clr), .en_we(en_we), .rdata(reg_rdata), .rvalid(reg_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            enable_q <= '0;
        else if (en_we)
            enable_q <= reg_wdata & EN_MASK;
    end

    assign irq = |(status & enable_q);

    assert_enable_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (enable_q == $past(reg_wdata & EN_MASK)));

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq);
endmodule

// File: tb/irq_vec_unit_tb.sv
module irq_vec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_vec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    // {pulse, clear mask, expected status}
    localparam logic [47:0] TABLE [0:5] = '{
        {16'h0001, 16'h0000, 16'h0001},
        {16'h6F1E, 16'h0000, 16'h6F1F},
        {16'h0000, 16'h0005, 16'h6F1A},
        {16'h80E0, 16'h0000, 16'h6F1A},
        {16'h0000, 16'hFFFF, 16'h0000},
        {16'h0010, 16'h0000, 16'h0010}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] p);
        ev_pulse = p;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d, output logic v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        v = reg_rvalid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rvalid", {15'b0, reg_rvalid}, 16'h0);
        check("R1 rdata", reg_rdata, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);
        rd(2'd0, d, v); check("R1 status", d, 16'h0);
        check("R10 rvalid", {15'b0, v}, 16'h1);
        rd(2'd1, d, v); check("R1 enable", d, 16'h0);
        rd(2'd2, d, v); check("R1 vector", d, 16'h0);
        @(negedge clk);
        check("R10 rvalid drops", {15'b0, reg_rvalid}, 16'h0);

        // R2 R3 R11 table walk
        for (int i = 0; i < 6; i++) begin
            if (TABLE[i][47:32] != 16'h0) pulse(TABLE[i][47:32]);
            if (TABLE[i][31:16] != 16'h0) wr(2'd0, TABLE[i][31:16]);
            rd(2'd0, d, v);
            check($sformatf("R2/R3/R11 row %0d", i), d, TABLE[i][15:0]);
        end
        check("R7 irq masked off", {15'b0, irq}, 16'h0);

        // R6 enable mask, R7 irq
        wr(2'd0, 16'hFFFF);
        pulse(16'h0100);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d, v); check("R6 enable mask", d, 16'h601F);
        check("R7 non-maskable pending", {15'b0, irq}, 16'h0);
        pulse(16'h2000);
        check("R7 irq raised", {15'b0, irq}, 16'h1);
        wr(2'd0, 16'h2000);
        check("R7 irq cleared", {15'b0, irq}, 16'h0);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'hFFFF);

        // R5 bus busy level
        bus_busy = 1'b1;
        @(negedge clk);
        rd(2'd0, d, v); check("R5 busy high", d, 16'h1000);
        wr(2'd0, 16'h1000);
        rd(2'd0, d, v); check("R5 busy write ignored", d, 16'h1000);
        bus_busy = 1'b0;
        @(negedge clk);
        rd(2'd0, d, v); check("R5 busy low", d, 16'h0000);

        // R4 collision: pulse bit 3 while clearing bits 1 and 3
        pulse(16'h000A);
        ev_pulse = 16'h0008;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h000A;
        @(negedge clk);
        ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, d, v); check("R4 collision", d, 16'h0008);
        wr(2'd0, 16'hFFFF);

        // R8 R9 vector stepping
        pulse(16'h001A);
        rd(2'd2, d, v); check("R8 first code", d, 16'd2);
        rd(2'd2, d, v); check("R9 second code", d, 16'd4);
        rd(2'd2, d, v); check("R9 third code", d, 16'd5);
        rd(2'd2, d, v); check("R8 none left", d, 16'd0);
        rd(2'd0, d, v); check("R9 status drained", d, 16'h0000);
        pulse(16'h0001);
        rd(2'd2, d, v); check("R8 arbitration code", d, 16'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule